// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block produces the 16x oversampling strobe that drives a UART's transmit and receive bit timing. A 32-bit configuration word holds a 16-bit integer divisor D and a 4-bit fraction F. F is counted in sixteenths of a clock. The block emits a one-cycle tick every D or D+1 clock cycles. A 4-bit accumulator decides which periods get the extra clock, so the average period is exactly D + F/16 clocks.

With a 16 MHz reference the baud rate is 16e6 / (16 * (D + F/16)). Some examples:
- D=1, F=0 gives 1,000,000 baud.
- D=2, F=0 gives 500,000 baud.
- D=8, F=11 gives about 115,200 baud.
- D=104, F=3 gives about 9,600 baud.

A pulse on the load input takes a new word and restarts the timing from a clean state. A divisor of zero silences the generator.

Top module: `uart_frac_baud`

## Requirements
- R1: Fields of the configuration word: D = {cfg_word_i[23:16], cfg_word_i[15:8]}, with bits 23:16 as the high byte. F = cfg_word_i[3:0]. Bits 31:24 and 7:4 have no effect on the tick timing.
- R2: After a load, the first tick is high in the cycle after the D-th rising edge following the edge that samples cfg_load_i. The accumulator starts from zero.
- R3: With F=0, ticks are spaced exactly D cycles apart. With D=1 and F=0, tick_o stays high every cycle.
- R4: With F>0, the spacing between tick k and tick k+1 (k counted from 1 after a load) is D + floor(k*F/16) - floor((k-1)*F/16). Any 16 consecutive periods therefore span 16*D + F cycles.
- R5: When D >= 2, each tick is high for exactly one cycle.
- R6: When the loaded divisor is zero, tick_o stays low.
- R7: A load in the middle of a run abandons the current period and the accumulated fraction. Timing under the new word then follows R2 and R4 as if no earlier run had happened. tick_o is low in the cycle after a load.
- R8: After reset the divisor is zero and tick_o is low until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | One-cycle strobe that takes cfg_word_i |
| cfg_word_i | input | 32 | Packed divisor word (see R1) |
| tick_o | output | 1 | 16x baud enable, one clock wide |

## Verification
The tick is a registered output. When a load is sampled on an edge, the counter restarts on that edge. The first tick then becomes visible just after the D-th following edge. Every later tick lands D or D+1 edges after the one before it, with the extra edge owed to the accumulator carry from the earlier tick.

The bench drives each load on a falling edge and samples tick_o on falling edges only. It counts falling edges from the first one after the load and records the index of every tick. It then compares the first index with D, and each difference between consecutive indices with the period that R4 gives. That formula is computed in the bench from D and F alone.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FRAC_W = 4;
  localparam int unsigned DIV_W  = 2 * BYTE_W;

  typedef struct packed {
    logic [BYTE_W-1:0] spare;
    logic [BYTE_W-1:0] div_hi;
    logic [BYTE_W-1:0] div_lo;
    logic [BYTE_W-1:0] frac;
  } fbg_cfg_t;
endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg
  import fbg_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned FW = FRAC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  fbg_cfg_t      word_i,
  output logic [DW-1:0] div_o,
  output logic [FW-1:0] frac_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      frac_o <= '0;
    end else if (load_i) begin
      div_o  <= DW'({word_i.div_hi, word_i.div_lo});
      frac_o <= word_i.frac[FW-1:0];
    end
  end
endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [DW-1:0] div_i,
  input  logic          stretch_i,
  output logic          wrap_o,
  output logic          tick_o
);
  localparam int unsigned LW = DW + 1;

  logic [DW-1:0] cnt_q;
  logic [LW-1:0] limit;
  logic          run;
  logic          match;

  assign run    = (div_i != '0);
  // last count of the period: D-1, or D when the accumulator carried
  assign limit  = ({1'b0, div_i} - LW'(1)) + LW'(stretch_i);
  assign match  = ({1'b0, cnt_q} == limit);
  assign wrap_o = run && !restart_i && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (restart_i || !run) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (match) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DW'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc #(
  parameter int unsigned FW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          wrap_i,
  input  logic [FW-1:0] frac_i,
  output logic          stretch_o
);
  logic [FW-1:0] acc_q;
  logic [FW:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      stretch_o <= 1'b0;
    end else if (restart_i) begin
      acc_q     <= '0;
      stretch_o <= 1'b0;
    end else if (wrap_i) begin
      acc_q     <= sum[FW-1:0];
      stretch_o <= sum[FW];
    end
  end
endmodule

// File: rtl/uart_frac_baud.sv
module uart_frac_baud
  import fbg_pkg::*;
#(
  parameter int unsigned DIV_WIDTH  = DIV_W,
  parameter int unsigned FRAC_WIDTH = FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  output logic             tick_o
);
  logic [DIV_WIDTH-1:0]  div_q;
  logic [FRAC_WIDTH-1:0] frac_q;
  logic                  wrap;
  logic                  stretch;

  fbg_cfg_reg #(.DW(DIV_WIDTH), .FW(FRAC_WIDTH)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .word_i (fbg_cfg_t'(cfg_word_i)),
    .div_o  (div_q),
    .frac_o (frac_q)
  );

  fbg_period_cnt #(.DW(DIV_WIDTH)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cfg_load_i),
    .div_i     (div_q),
    .stretch_i (stretch),
    .wrap_o    (wrap),
    .tick_o    (tick_o)
  );

  fbg_frac_acc #(.FW(FRAC_WIDTH)) i_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cfg_load_i),
    .wrap_i    (wrap),
    .frac_i    (frac_q),
    .stretch_o (stretch)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned FW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_load_i,
  input logic          tick_o,
  input logic [DW-1:0] div_i,
  input logic [FW-1:0] frac_i
);
  logic [DW+1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (cfg_load_i) begin
      gap_q  <= (DW+2)'(1);
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= (DW+2)'(1);
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + (DW+2)'(1);
    end
  end

  a_r6_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0) |-> !tick_o);

  a_r7_load_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> !tick_o);

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > DW'(1) && !cfg_load_i) |=> !tick_o);

  a_r3_div1_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i == DW'(1) && frac_i == '0 && !cfg_load_i) |=> tick_o);

  a_r4_gap_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |->
      (gap_q == (DW+2)'(div_i) || gap_q == (DW+2)'(div_i) + (DW+2)'(1)));
endmodule

bind uart_frac_baud fbg_checker #(.DW(DIV_WIDTH), .FW(FRAC_WIDTH)) i_fbg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .tick_o     (tick_o),
  .div_i      (div_q),
  .frac_i     (frac_q)
);

// File: tb/test_uart_frac_baud.sv
module test_uart_frac_baud;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        tick_o;

  int checks = 0;
  int errors = 0;
  int stamps [0:39];
  int n_got;

  always #2.5 clk_i = ~clk_i;

  uart_frac_baud i_uart_frac_baud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_load_i (cfg_load),
    .cfg_word_i (cfg_word),
    .tick_o     (tick_o)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int d, input int f, input int k);
    return d + (k * f) / 16 - ((k - 1) * f) / 16;
  endfunction

  task automatic load_cfg(input logic [31:0] w);
    @(negedge clk_i);
    cfg_word = w;
    cfg_load = 1'b1;
    @(negedge clk_i);
    cfg_load = 1'b0;
  endtask

  // index 0 is the falling edge right after the load edge
  task automatic collect(input int n, input int maxc);
    n_got = 0;
    for (int k = 0; k <= maxc && n_got < n; k++) begin
      if (k > 0) @(negedge clk_i);
      if (tick_o) begin
        stamps[n_got] = k;
        n_got++;
      end
    end
  endtask

  task automatic check_run(input string req, input int d, input int f, input int n);
    check_eq({req, " tick count"}, n_got, n);
    check_eq({req, " first tick"}, stamps[0], d);
    for (int i = 1; i < n_got; i++)
      check_eq({req, " period"}, stamps[i] - stamps[i-1], exp_period(d, f, i));
  endtask

  task automatic t_reset;
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (tick_o) seen++;
    end
    check_eq("R8 no tick after reset", seen, 0);
  endtask

  task automatic t_integer;
    load_cfg(32'h0000_0200);
    collect(9, 40);
    check_run("R3 R5 D=2", 2, 0, 9);
  endtask

  task automatic t_div1;
    load_cfg(32'h0000_0100);
    collect(16, 20);
    check_run("R3 D=1 steady", 1, 0, 16);
  endtask

  task automatic t_fraction;
    load_cfg(32'h0000_080b);
    collect(17, 300);
    check_run("R4 D=8 F=11", 8, 11, 17);
    check_eq("R4 16-period span", stamps[16] - stamps[0], 16 * 8 + 11);
  endtask

  task automatic t_slow;
    load_cfg(32'h0000_6803);
    collect(17, 2000);
    check_run("R4 D=104 F=3", 104, 3, 17);
    check_eq("R4 16-period span slow", stamps[16] - stamps[0], 16 * 104 + 3);
  endtask

  task automatic t_fields;
    load_cfg(32'hA500_02F0);
    collect(6, 40);
    check_run("R1 ignored bits", 2, 0, 6);
    load_cfg(32'h0001_0000);
    collect(2, 700);
    check_run("R1 high byte weight", 256, 0, 2);
  endtask

  task automatic t_zero;
    int seen = 0;
    load_cfg(32'h0000_080b);
    collect(2, 40);
    load_cfg(32'h0000_000b);
    for (int i = 0; i < 300; i++) begin
      if (i > 0) @(negedge clk_i);
      if (tick_o) seen++;
    end
    check_eq("R6 zero divisor silent", seen, 0);
  endtask

  task automatic t_reload;
    load_cfg(32'h0000_080b);
    collect(2, 40);
    repeat (3) @(negedge clk_i);
    load_cfg(32'h0000_030c);
    check_eq("R7 tick low after load", int'(tick_o), 0);
    collect(9, 60);
    check_run("R7 R2 reload D=3 F=12", 3, 12, 9);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_integer();
    t_div1();
    t_fraction();
    t_slow();
    t_fields();
    t_zero();
    t_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule